// File: doc/BRIEF.md
# I2C Paged Memory Target

This block is an I2C target that gives a bus master byte access to an on-chip memory of two equal pages. A 7-bit target address selects the memory. Its top four bits are a fixed family code. The next two bits are compared against two strap inputs, so that four such targets can share one bus. The last address bit selects the page. After a write-addressed target byte, the master sends a 16-bit in-page address, high byte first, and then any number of data bytes. After a repeated START and a read-addressed target byte, the block returns bytes starting at the current address. The address steps by one after every data byte in either direction, and it wraps inside the selected page.

SCL and SDA are sampled on a fast system clock through synchronisers. SDA is driven as open drain: `sda_o` is held low and `sda_oe` pulls the line. The block also recognises the high-speed master code after a START. It raises a flag that stays set until the next STOP, so surrounding logic can switch filter or timing settings. With default parameters each page holds 256 bytes, and the upper address bits alias onto it. Setting the in-page width to 16 gives the full two 64 KB pages.

Top module: `i2c_paged_mem`

## Requirements
- R1: After reset, `sda_oe` is 0 (SDA released) and `hs_mode` is 0.
- R2: A target byte whose bits 7:4 are 1010b and whose bits 3:2 equal `dev_sel[1:0]` is acknowledged by pulling SDA low in the ninth clock. Bit 0 is the direction: 0 for write, 1 for read.
- R3: A target byte with a different family code or different device bits is not acknowledged. Every following byte up to the next START or STOP is also left unacknowledged, and no memory location is changed.
- R4: Bit 1 of the target byte selects the page. The same in-page address in page 0 and in page 1 holds independent data.
- R5: In a write transfer, the two bytes after the target byte form the in-page address, high byte first. Each further byte is stored at the current address and acknowledged, and the address then steps by one.
- R6: A repeated START followed by a read-addressed target byte returns the byte at the current address, MSB first. Each byte the master acknowledges is followed by the next address's byte.
- R7: When the master does not acknowledge a read byte, the target releases SDA and drives nothing more until the next START or STOP.
- R8: Stepping from in-page address 0xFFFF gives 0x0000 in the same page, for both writes and reads.
- R9: A byte of the form 00001xxxb in the target-byte position sets `hs_mode` and is not acknowledged.
- R10: A STOP (SDA rising while SCL is high) clears `hs_mode`. A repeated START does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_o | output | 1 | SDA drive value, always 0 (open drain) |
| sda_oe | output | 1 | SDA pull-down enable, registered |
| dev_sel | input | 2 | Device strap bits compared with target byte bits 3:2 |
| hs_mode | output | 1 | High-speed mode flag, set by master code, cleared by STOP |

## Verification
The memory function is tested with several transfer patterns. A single-byte write and read test the address phase and the byte order. A four-byte burst tests the address stepping in both directions. The same in-page address is used in both pages to show that the page bit is part of the storage address. A burst that crosses 0xFFFF shows wrapping inside the page, as opposed to carrying into the other page. Transfers to a wrong family code or wrong straps must leave earlier data unchanged. A read ended by a NACK, where the next byte has a 0 MSB, would expose a target that kept driving SDA. A master-code sequence followed by a normal write separates the speed flag from the data path.

// File: rtl/i2cpm_pkg.sv
package i2cpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_state_e;

  typedef enum logic [1:0] {
    K_SLV,
    K_AHI,
    K_ALO,
    K_DAT
  } byte_kind_e;

endpackage

// File: rtl/i2cpm_line_sync.sv
module i2cpm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  always_comb begin
    scl_s     = scl_p[STAGES-1];
    sda_s     = sda_p[STAGES-1];
    scl_rise  = scl_s & ~scl_d;
    scl_fall  = ~scl_s & scl_d;
    // SDA edges count as bus conditions only while SCL stays high
    start_evt = scl_s & scl_d & sda_d & ~sda_s;
    stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
  end

endmodule

// File: rtl/i2cpm_ram.sv
module i2cpm_ram #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/i2c_paged_mem.sv
module i2c_paged_mem #(
  parameter int         PAGE_AW     = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] FAMILY_ID   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic [1:0] dev_sel,
  output logic       hs_mode
);
  import i2cpm_pkg::*;

  localparam int RAM_AW = PAGE_AW + 1;
  localparam int BITS   = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2cpm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  bus_state_e  state;
  byte_kind_e  kind;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg;
  logic        page;
  logic [15:0] addr;
  logic        go_tx;
  logic        mem_we;
  logic        byte_done;
  logic        id_match;
  logic        is_mcode;
  logic [7:0]  rd_data;
  logic [RAM_AW-1:0] ram_addr;

  assign sda_o = 1'b0;

  always_comb begin
    byte_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'(BITS))
                && !start_evt && !stop_evt;
    mem_we    = byte_done && (kind == K_DAT);
    id_match  = (shreg[7:4] == FAMILY_ID) && (shreg[3:2] == dev_sel);
    is_mcode  = (shreg[7:3] == 5'b00001);
    ram_addr  = {page, addr[PAGE_AW-1:0]};
  end

  i2cpm_ram #(.DW(8), .AW(RAM_AW)) u_ram (
    .clk  (clk),
    .we   (mem_we),
    .addr (ram_addr),
    .wdata(shreg),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind    <= K_SLV;
      bit_cnt <= '0;
      shreg   <= '0;
      page    <= 1'b0;
      addr    <= '0;
      go_tx   <= 1'b0;
      sda_oe  <= 1'b0;
      hs_mode <= 1'b0;
    end else if (stop_evt) begin
      state   <= ST_IDLE;
      sda_oe  <= 1'b0;
      hs_mode <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_RX;
      kind    <= K_SLV;
      bit_cnt <= '0;
      go_tx   <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && bit_cnt != 4'(BITS)) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            case (kind)
              K_SLV: begin
                if (is_mcode) begin
                  hs_mode <= 1'b1;
                  state   <= ST_IDLE;
                end else if (id_match) begin
                  page   <= shreg[1];
                  go_tx  <= shreg[0];
                  kind   <= K_AHI;
                  sda_oe <= 1'b1;
                  state  <= ST_RX_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              K_AHI: begin
                addr[15:8] <= shreg;
                kind       <= K_ALO;
                sda_oe     <= 1'b1;
                state      <= ST_RX_ACK;
              end
              K_ALO: begin
                addr[7:0] <= shreg;
                kind      <= K_DAT;
                sda_oe    <= 1'b1;
                state     <= ST_RX_ACK;
              end
              default: begin
                addr   <= addr + 16'd1;
                sda_oe <= 1'b1;
                state  <= ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            if (go_tx) begin
              sda_oe  <= ~rd_data[7];
              shreg   <= {rd_data[6:0], 1'b0};
              bit_cnt <= 4'd1;
              state   <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'(BITS)) begin
              sda_oe  <= 1'b0;
              addr    <= addr + 16'd1;
              bit_cnt <= '0;
              state   <= ST_TX_ACK;
            end else begin
              sda_oe  <= ~shreg[7];
              shreg   <= {shreg[6:0], 1'b0};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise && sda_s) begin
            state <= ST_IDLE;
          end else if (scl_fall) begin
            sda_oe  <= ~rd_data[7];
            shreg   <= {rd_data[6:0], 1'b0};
            bit_cnt <= 4'd1;
            state   <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  // R1: released bus and standard speed straight after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sda_oe && !hs_mode));

  // R5 and R8: every stored byte advances the address by one, 16-bit wrap
  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (addr == $past(addr) + 16'd1));

  // R7: master NACK seen on the synchronised line frees SDA
  p_nack_release_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_ACK && scl_rise && sda_s && !start_evt && !stop_evt)
      |=> (!sda_oe && state == ST_IDLE));

  // R9: entering high-speed mode never comes with an acknowledge
  p_mcode_noack_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode) |-> !sda_oe);

  // R10: a STOP condition always leaves standard speed
  p_stop_clears_hs_r10: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !hs_mode);

endmodule

// File: tb/sim_i2c_paged_mem.sv
module sim_i2c_paged_mem;

  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda_low = 1'b0;
  logic [1:0] dev_sel = 2'b10;
  logic       sda_o, sda_oe, hs_mode;
  logic       sda_bus;
  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = !(m_sda_low || (sda_oe && !sda_o));

  i2c_paged_mem u0 (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (m_scl),
    .sda_i  (sda_bus),
    .sda_o  (sda_o),
    .sda_oe (sda_oe),
    .dev_sel(dev_sel),
    .hs_mode(hs_mode)
  );

  function automatic logic [7:0] tgt(input logic [1:0] dv, input logic pg, input logic rd);
    return {4'b1010, dv, pg, rd};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wt(Q);
    m_scl = 1'b1;     wt(Q);
    m_sda_low = 1'b1; wt(Q);
    m_scl = 1'b0;     wt(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wt(Q);
    m_scl = 1'b1;     wt(Q);
    m_sda_low = 1'b0; wt(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; wt(Q);
      m_scl = 1'b1;      wt(2*Q);
      m_scl = 1'b0;      wt(Q);
    end
    m_sda_low = 1'b0; wt(Q);
    m_scl = 1'b1;     wt(Q);
    ack = !sda_bus;   wt(Q);
    m_scl = 1'b0;     wt(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(Q);
      m_scl = 1'b1; wt(Q);
      b[i] = sda_bus; wt(Q);
      m_scl = 1'b0; wt(Q);
    end
    m_sda_low = give_ack; wt(Q);
    m_scl = 1'b1;         wt(2*Q);
    m_scl = 1'b0;         wt(Q);
    m_sda_low = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] slv, input logic [15:0] a,
                          input logic [31:0] d, input int n, output int acks);
    bit k;
    acks = 0;
    bus_start();
    send_byte(slv, k);      acks += int'(k);
    send_byte(a[15:8], k);  acks += int'(k);
    send_byte(a[7:0], k);   acks += int'(k);
    for (int i = 0; i < n; i++) begin
      send_byte(d[31-8*i -: 8], k); acks += int'(k);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] slv, input logic [15:0] a, input int n,
                         output logic [31:0] d, output int acks);
    bit k;
    logic [7:0] b;
    acks = 0;
    d = '0;
    bus_start();
    send_byte(slv, k);          acks += int'(k);
    send_byte(a[15:8], k);      acks += int'(k);
    send_byte(a[7:0], k);       acks += int'(k);
    bus_start();
    send_byte(slv | 8'h01, k);  acks += int'(k);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n-1, b);
      d[31-8*i -: 8] = b;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 sda_oe after reset", 32'(sda_oe), 32'd0);
    chk("R1 hs_mode after reset", 32'(hs_mode), 32'd0);
    chk("R1 bus released", 32'(sda_bus), 32'd1);
  endtask

  task automatic t_single();
    int acks;
    logic [31:0] d;
    do_write(tgt(2'b10, 1'b0, 1'b0), 16'h1234, 32'h3C00_0000, 1, acks);
    chk("R2 R5 single write acks", 32'(acks), 32'd4);
    do_read(tgt(2'b10, 1'b0, 1'b0), 16'h1234, 1, d, acks);
    chk("R2 read acks", 32'(acks), 32'd4);
    chk("R6 single read data", d[31:24], 32'h3C);
  endtask

  task automatic t_pages();
    int acks;
    logic [31:0] d;
    do_write(tgt(2'b10, 1'b0, 1'b0), 16'h0010, 32'h1100_0000, 1, acks);
    do_write(tgt(2'b10, 1'b1, 1'b0), 16'h0010, 32'h2200_0000, 1, acks);
    do_read(tgt(2'b10, 1'b0, 1'b0), 16'h0010, 1, d, acks);
    chk("R4 page0 data", d[31:24], 32'h11);
    do_read(tgt(2'b10, 1'b1, 1'b0), 16'h0010, 1, d, acks);
    chk("R4 page1 data", d[31:24], 32'h22);
  endtask

  task automatic t_burst();
    int acks;
    logic [31:0] d;
    do_write(tgt(2'b10, 1'b0, 1'b0), 16'h0040, 32'hA132_C344, 4, acks);
    chk("R5 burst write acks", 32'(acks), 32'd7);
    do_read(tgt(2'b10, 1'b0, 1'b0), 16'h0040, 4, d, acks);
    chk("R6 burst read data", d, 32'hA132_C344);
    do_read(tgt(2'b10, 1'b0, 1'b0), 16'h0042, 2, d, acks);
    chk("R6 mid-burst read data", d[31:16], 32'hC344);
  endtask

  task automatic t_mismatch();
    int acks;
    logic [31:0] d;
    do_write(tgt(2'b01, 1'b0, 1'b0), 16'h0010, 32'h9900_0000, 1, acks);
    chk("R3 wrong straps acks", 32'(acks), 32'd0);
    do_write({4'b1011, 2'b10, 1'b0, 1'b0}, 16'h0010, 32'h9900_0000, 1, acks);
    chk("R3 wrong family acks", 32'(acks), 32'd0);
    do_read(tgt(2'b10, 1'b0, 1'b0), 16'h0010, 1, d, acks);
    chk("R3 memory unchanged", d[31:24], 32'h11);
  endtask

  task automatic t_wrap();
    int acks;
    logic [31:0] d;
    do_write(tgt(2'b10, 1'b0, 1'b0), 16'h0000, 32'h5500_0000, 1, acks);
    do_write(tgt(2'b10, 1'b1, 1'b0), 16'hFFFF, 32'hAABB_0000, 2, acks);
    chk("R8 wrap write acks", 32'(acks), 32'd5);
    do_read(tgt(2'b10, 1'b1, 1'b0), 16'h0000, 1, d, acks);
    chk("R8 write wrapped into page1 0x0000", d[31:24], 32'hBB);
    do_read(tgt(2'b10, 1'b0, 1'b0), 16'h0000, 1, d, acks);
    chk("R8 page0 0x0000 untouched", d[31:24], 32'h55);
    do_read(tgt(2'b10, 1'b1, 1'b0), 16'hFFFF, 2, d, acks);
    chk("R8 read wraps in page", d[31:16], 32'hAABB);
  endtask

  task automatic t_nack_release();
    bit k;
    logic [7:0] b;
    bus_start();
    send_byte(tgt(2'b10, 1'b0, 1'b0), k);
    send_byte(8'h00, k);
    send_byte(8'h40, k);
    bus_start();
    send_byte(tgt(2'b10, 1'b0, 1'b1), k);
    recv_byte(1'b0, b);
    chk("R7 byte before nack", 32'(b), 32'hA1);
    wt(Q);
    m_scl = 1'b1; wt(Q);
    chk("R7 sda released after nack", 32'(sda_bus), 32'd1);
    chk("R7 sda_oe low after nack", 32'(sda_oe), 32'd0);
    m_scl = 1'b0; wt(Q);
    bus_stop();
  endtask

  task automatic t_hs();
    bit k;
    int acks;
    logic [31:0] d;
    bus_start();
    send_byte(8'h0B, k);
    chk("R9 master code not acked", 32'(k), 32'd0);
    chk("R9 hs_mode set", 32'(hs_mode), 32'd1);
    bus_start();
    send_byte(tgt(2'b10, 1'b0, 1'b0), k);
    chk("R10 hs kept over repeated start", 32'(hs_mode), 32'd1);
    send_byte(8'h12, k);
    send_byte(8'h34, k);
    send_byte(8'h5A, k);
    chk("R9 data acked in hs", 32'(k), 32'd1);
    bus_stop();
    chk("R10 stop clears hs_mode", 32'(hs_mode), 32'd0);
    do_read(tgt(2'b10, 1'b0, 1'b0), 16'h1234, 1, d, acks);
    chk("R5 write during hs stored", d[31:24], 32'h5A);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(3);
    t_reset();
    t_single();
    t_pages();
    t_burst();
    t_mismatch();
    t_wrap();
    t_nack_release();
    t_hs();
    wt(10);
    report();
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      report();
    end
  end

endmodule